// File: doc/BRIEF.md
# Configuration Space Access Window

This block gives a host processor access to the configuration registers of the functions on a peripheral bus through only two I/O locations. One location is a 32-bit selector: the host writes into it an enable flag, a bus number, a device/function number and a dword register index. The other location is a four-byte data window. Byte, word and dword reads and writes to that window are turned into configuration requests aimed at the selected function, at the byte offset formed from the selector's register index and the window byte address used by the host.

On the function side the block drives a request with device/function number, byte offset, access length, byte enables and lane-aligned write data. It samples a presence flag and a dword-aligned read word for the function it currently addresses. A request goes out only when the selector is enabled, its two low bits are zero, it names the home bus and a function answers present. Any other window read returns zero, and any other window write is dropped. Read data reaches the host one clock after the read strobe.

Top module: `cfg_win_top`

## Requirements
- R1: After reset the selector holds zero, `hostRdValid` is low and no function request is issued.
- R2: A write to the selector (`hostSel`=0) with `hostLen` equal to 2'b10 or 2'b11 (dword) stores all 32 bits of `hostWrData`, and a later selector read returns exactly that value.
- R3: A selector write with `hostLen` 2'b00 (byte) or 2'b01 (word) leaves the selector unchanged.
- R4: `cfgDevFn` equals selector bits 15:8, and `cfgOffset` equals selector bits 7:2 followed by `hostByteAddr` in bits 1:0.
- R5: While selector bit 31 is zero, window accesses raise no `cfgReq` and window reads return zero.
- R6: While selector bits 1:0 are nonzero, window accesses raise no `cfgReq` and window reads return zero.
- R7: When selector bits 23:16 are not zero (only bus 0 is populated) or `cfgPresent` is low, window accesses raise no `cfgReq` and window reads return zero.
- R8: A forwarded window write raises `cfgReq` and `cfgWr` in the same cycle, passes `hostLen` to `cfgLen`, places `hostWrData` byte k on lane `hostByteAddr`+k of `cfgWrData`, and sets `cfgByteEn` bit i for each of those lanes below 4 (1, 2 or 4 bytes for `hostLen` 2'b00, 2'b01, dword); bytes falling past lane 3 are dropped.
- R9: A forwarded window read returns in `hostRdData` byte k equal to `cfgRdData` lane `hostByteAddr`+k for k below the access length and below lane 4, and zero in every other bit (little-endian: a byte read at offset n gives byte n in bits 7:0).
- R10: `hostRdValid` is high in exactly the cycle after an accepted read strobe, and `hostRdData` holds its value until the next read completes.
- R11: When `hostWr` and `hostRd` are high together, the write is performed and the read is ignored (no `hostRdValid` follows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | 0 selects the selector register, 1 selects the data window |
| hostByteAddr | input | 2 | Byte address within the data window |
| hostLen | input | 2 | Access length: 00 byte, 01 word, 10/11 dword |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWrData | input | 32 | Host write data, right-justified |
| hostRdData | output | 32 | Host read data, right-justified |
| hostRdValid | output | 1 | Read data valid, one cycle after the read strobe |
| cfgReq | output | 1 | Configuration request to the addressed function |
| cfgWr | output | 1 | Request is a write |
| cfgDevFn | output | 8 | Device/function number addressed |
| cfgOffset | output | 8 | Configuration byte offset |
| cfgLen | output | 2 | Access length passed through |
| cfgByteEn | output | 4 | Byte lanes written |
| cfgWrData | output | 32 | Lane-aligned write data |
| cfgPresent | input | 1 | A function exists at `cfgDevFn` |
| cfgRdData | input | 32 | Dword-aligned configuration word at `cfgOffset` |

## Verification
Each cycle the assertions check that no request leaves while the selector is disabled, misaligned or pointed off the home bus, or while the addressed function is absent. They also check that the selector changes only on a dword selector write, that read-valid follows exactly the cycles with an accepted read, and that write byte enables stay within the four lanes. Only the bench scenarios can show the data itself: selector readback after partial writes, the lane extraction and masking of byte and word reads including a word at lane 3, lane placement of write data, and zero returns for absent functions and nonzero buses.

// File: rtl/cfg_win_pkg.sv
package cfg_win_pkg;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic latchWr;  // store host data into the selector
    logic fwdAcc;   // window access forwarded to a function
    logic fwdWr;    // forwarded access is a write
    logic rdLatch;  // read returns the selector
    logic rdFwd;    // read returns function data
    logic rdDone;   // a read completes next cycle
  } winStrobes_t;

  // Number of bytes carried by a length code.
  function automatic logic [2:0] lenToBytes(input logic [1:0] len);
    case (len)
      2'b00:   lenToBytes = 3'd1;
      2'b01:   lenToBytes = 3'd2;
      default: lenToBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfg_win_ctrl.sv
module cfg_win_ctrl
  import cfg_win_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int HOME_BUS = 0
) (
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostLenDw,
  input  logic              selEnable,
  input  logic [1:0]        selLow,
  input  logic [BUS_W-1:0]  selBus,
  input  logic              cfgPresent,
  output winStrobes_t       st
);

  logic rdOp;
  logic gateOpen;

  // A write takes precedence over a simultaneous read.
  assign rdOp = hostRd & ~hostWr;

  assign gateOpen = selEnable && (selLow == 2'b00) &&
                    (selBus == BUS_W'(HOME_BUS)) && cfgPresent;

  always_comb begin
    st         = '0;
    st.latchWr = hostWr & ~hostSel & hostLenDw;
    st.fwdWr   = hostWr & hostSel & gateOpen;
    st.rdFwd   = rdOp & hostSel & gateOpen;
    st.fwdAcc  = st.fwdWr | st.rdFwd;
    st.rdLatch = rdOp & ~hostSel;
    st.rdDone  = rdOp;
  end

endmodule

// File: rtl/cfg_win_dpath.sv
module cfg_win_dpath
  import cfg_win_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUS_W = 8,
  parameter int DEVFN_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  winStrobes_t         st,
  input  logic [$clog2(DATA_W/8)-1:0] hostByteAddr,
  input  logic [1:0]          hostLen,
  input  logic [DATA_W-1:0]   hostWrData,
  output logic [DATA_W-1:0]   hostRdData,
  output logic                hostRdValid,
  output logic                selEnable,
  output logic [1:0]          selLow,
  output logic [BUS_W-1:0]    selBus,
  output logic [DEVFN_W-1:0]  cfgDevFn,
  output logic [7:0]          cfgOffset,
  output logic [DATA_W/8-1:0] cfgByteEn,
  output logic [DATA_W-1:0]   cfgWrData,
  input  logic [DATA_W-1:0]   cfgRdData
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int BUS_LO = 16;
  localparam int DF_LO  = 8;

  logic [DATA_W-1:0]  selReg;
  logic [2:0]         nBytes;
  logic [2*LANES-1:0] baseMask;
  logic [2*LANES-1:0] wideEn;
  logic [DATA_W-1:0]  laneMask;
  logic [DATA_W-1:0]  rdShifted;
  logic [LANE_W-1:0]  lane;

  assign lane      = hostByteAddr;
  assign nBytes    = lenToBytes(hostLen);
  assign selEnable = selReg[DATA_W-1];
  assign selLow    = selReg[1:0];
  assign selBus    = selReg[BUS_LO +: BUS_W];
  assign cfgDevFn  = selReg[DF_LO +: DEVFN_W];
  assign cfgOffset = {selReg[7:LANE_W], lane};

  // Bytes of the access, placed from the addressed lane upward.
  always_comb begin
    for (int i = 0; i < 2*LANES; i++) begin
      baseMask[i] = (i < int'(nBytes));
    end
  end
  assign wideEn    = baseMask << lane;
  assign cfgByteEn = wideEn[LANES-1:0];
  assign cfgWrData = hostWrData << {lane, 3'b000};

  // Read path: bring the addressed lane to bit 0, keep only the access length.
  assign rdShifted = cfgRdData >> {lane, 3'b000};
  for (genvar g = 0; g < LANES; g++) begin : gLaneMask
    assign laneMask[g*8 +: 8] = {8{baseMask[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg      <= '0;
      hostRdData  <= '0;
      hostRdValid <= 1'b0;
    end else begin
      if (st.latchWr) selReg <= hostWrData;
      hostRdValid <= st.rdDone;
      if (st.rdDone) begin
        if (st.rdLatch)    hostRdData <= selReg;
        else if (st.rdFwd) hostRdData <= rdShifted & laneMask;
        else               hostRdData <= '0;
      end
    end
  end

  // R5: nothing is forwarded while the selector is disabled
  a_r5_fwd_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    st.fwdAcc |-> selReg[DATA_W-1]);

  // R6: nothing is forwarded while the selector is misaligned
  a_r6_fwd_needs_align: assert property (@(posedge clk) disable iff (!rstN)
    st.fwdAcc |-> (selReg[1:0] == 2'b00));

  // R3: the selector only changes on an accepted dword selector write
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.latchWr |=> $stable(selReg));

  // R10: read valid follows exactly the accepted read strobes
  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    st.rdDone |=> hostRdValid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdDone |=> !hostRdValid);

  // R8: a forwarded write enables at least one lane and never more than four
  a_r8_byte_en_range: assert property (@(posedge clk) disable iff (!rstN)
    st.fwdWr |-> (cfgByteEn != '0) && ($countones(cfgByteEn) <= LANES));

endmodule

// File: rtl/cfg_win_top.sv
module cfg_win_top
  import cfg_win_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUS_W = 8,
  parameter int DEVFN_W = 8,
  parameter int HOME_BUS = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic [1:0]        hostByteAddr,
  input  logic [1:0]        hostLen,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              hostRdValid,
  output logic              cfgReq,
  output logic              cfgWr,
  output logic [7:0]        cfgDevFn,
  output logic [7:0]        cfgOffset,
  output logic [1:0]        cfgLen,
  output logic [3:0]        cfgByteEn,
  output logic [31:0]       cfgWrData,
  input  logic              cfgPresent,
  input  logic [31:0]       cfgRdData
);

  winStrobes_t       st;
  logic              selEnable;
  logic [1:0]        selLow;
  logic [BUS_W-1:0]  selBus;

  cfg_win_ctrl #(.BUS_W(BUS_W), .HOME_BUS(HOME_BUS)) ctrl_i (
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostLenDw  (hostLen[1]),
    .selEnable  (selEnable),
    .selLow     (selLow),
    .selBus     (selBus),
    .cfgPresent (cfgPresent),
    .st         (st)
  );

  cfg_win_dpath #(.DATA_W(DATA_W), .BUS_W(BUS_W), .DEVFN_W(DEVFN_W)) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .hostByteAddr (hostByteAddr),
    .hostLen      (hostLen),
    .hostWrData   (hostWrData),
    .hostRdData   (hostRdData),
    .hostRdValid  (hostRdValid),
    .selEnable    (selEnable),
    .selLow       (selLow),
    .selBus       (selBus),
    .cfgDevFn     (cfgDevFn),
    .cfgOffset    (cfgOffset),
    .cfgByteEn    (cfgByteEn),
    .cfgWrData    (cfgWrData),
    .cfgRdData    (cfgRdData)
  );

  assign cfgReq = st.fwdAcc;
  assign cfgWr  = st.fwdWr;
  assign cfgLen = hostLen;

  // R7: a request only goes to a function that answers present on the home bus
  a_r7_req_needs_present: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgPresent && (selBus == BUS_W'(HOME_BUS)));

  // R11: a simultaneous write and read never forwards as a read
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostRd && cfgReq) |-> cfgWr);

endmodule

// File: tb/cfg_win_top_tb.sv
`timescale 1ns/100ps
module cfg_win_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic [1:0]  hostByteAddr = '0;
  logic [1:0]  hostLen = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostRdValid;
  logic        cfgReq, cfgWr;
  logic [7:0]  cfgDevFn, cfgOffset;
  logic [1:0]  cfgLen;
  logic [3:0]  cfgByteEn;
  logic [31:0] cfgWrData;
  logic        cfgPresent;
  logic [31:0] cfgRdData;

  int checks = 0;
  int errors = 0;
  logic [31:0] mSel = '0;
  logic [31:0] expQ[$];
  string tagQ[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_win_top dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostByteAddr(hostByteAddr),
    .hostLen(hostLen), .hostWr(hostWr), .hostRd(hostRd), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid), .cfgReq(cfgReq),
    .cfgWr(cfgWr), .cfgDevFn(cfgDevFn), .cfgOffset(cfgOffset), .cfgLen(cfgLen),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgPresent(cfgPresent),
    .cfgRdData(cfgRdData)
  );

  function automatic logic isPresent(input logic [7:0] df);
    return (df == 8'h00) || (df == 8'h08) || (df == 8'h10);
  endfunction

  function automatic logic [31:0] devWord(input logic [7:0] df, input logic [7:0] dw);
    return {df ^ 8'h11, dw, 8'h5A + df, dw ^ 8'hC3};
  endfunction

  // Function model
  assign cfgPresent = isPresent(cfgDevFn);
  assign cfgRdData  = cfgPresent ? devWord(cfgDevFn, {cfgOffset[7:2], 2'b00}) : 32'h0;

  function automatic int nOf(input logic [1:0] len);
    return (len == 2'b00) ? 1 : (len == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic gateOk();
    return mSel[31] && (mSel[1:0] == 2'b00) && (mSel[23:16] == 8'h00) &&
           isPresent(mSel[15:8]);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one host access per call; checks the function-side outputs.
  task automatic hostOp(input logic sel, input logic [1:0] ba, input logic [1:0] len,
                        input logic wr, input logic rd, input logic [31:0] wd,
                        input string tag);
    int n;
    logic [31:0] exp;
    logic [31:0] w;
    logic [3:0] be;
    logic [31:0] wdx;
    logic fwd;
    @(negedge clk);
    hostSel = sel; hostByteAddr = ba; hostLen = len;
    hostWr = wr; hostRd = rd; hostWrData = wd;
    n = nOf(len);
    fwd = sel && (wr || rd) && gateOk();
    #1;
    chk(cfgReq == fwd, {tag, " R5/R6/R7 cfgReq"}, {31'b0, cfgReq}, {31'b0, fwd});
    if (sel) begin
      chk(cfgDevFn == mSel[15:8], {tag, " R4 devfn"}, {24'b0, cfgDevFn}, {24'b0, mSel[15:8]});
      chk(cfgOffset == {mSel[7:2], ba}, {tag, " R4 offset"}, {24'b0, cfgOffset}, {24'b0, mSel[7:2], ba});
    end
    if (fwd && wr) begin
      be = '0; wdx = '0;
      for (int k = 0; k < 4; k++)
        if (k < n && int'(ba) + k < 4) begin
          be[int'(ba) + k] = 1'b1;
          wdx[(int'(ba) + k)*8 +: 8] = wd[k*8 +: 8];
        end
      chk(cfgWr == 1'b1, {tag, " R8 cfgWr"}, {31'b0, cfgWr}, 32'h1);
      chk(cfgByteEn == be, {tag, " R8 byteEn"}, {28'b0, cfgByteEn}, {28'b0, be});
      chk((cfgWrData & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}}) == wdx,
          {tag, " R8 wrData"}, cfgWrData, wdx);
      chk(cfgLen == len, {tag, " R8 len"}, {30'b0, cfgLen}, {30'b0, len});
    end
    if (rd && !wr) begin
      if (!sel) exp = mSel;
      else if (!gateOk()) exp = 32'h0;
      else begin
        w = devWord(mSel[15:8], {mSel[7:2], 2'b00});
        exp = '0;
        for (int k = 0; k < 4; k++)
          if (k < n && int'(ba) + k < 4) exp[k*8 +: 8] = w[(int'(ba) + k)*8 +: 8];
      end
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    if (wr && !sel && len[1]) mSel = wd;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
  endtask

  // Monitor: compares completed reads against the scoreboard.
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10/R11 unexpected read valid: actual %h expected none", hostRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(hostRdData == e, {t, " read data"}, hostRdData, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hostRdValid == 1'b0, "R1 valid low", {31'b0, hostRdValid}, 32'h0);
    chk(cfgReq == 1'b0, "R1 no request", {31'b0, cfgReq}, 32'h0);
    rstN = 1'b1;
    hostOp(0, 2'd0, 2'b10, 0, 1, 32'h0, "R1 selector zero");
    // R2: dword selector write and readback
    hostOp(0, 2'd0, 2'b10, 1, 0, 32'h8000_0800, "R2 write");
    hostOp(0, 2'd0, 2'b10, 0, 1, 32'h0, "R2 readback");
    // R3: partial selector writes ignored
    hostOp(0, 2'd0, 2'b01, 1, 0, 32'h1234_5678, "R3 word write");
    hostOp(0, 2'd0, 2'b00, 1, 0, 32'h0000_00FF, "R3 byte write");
    hostOp(0, 2'd0, 2'b10, 0, 1, 32'h0, "R3 readback");
    // R9/R4: dword read at register 0 of devfn 8
    hostOp(1, 2'd0, 2'b10, 0, 1, 32'h0, "R9 dword read");
    hostOp(0, 2'd0, 2'b11, 1, 0, 32'h8000_0810, "R2 alt dword code");
    hostOp(1, 2'd2, 2'b00, 0, 1, 32'h0, "R9 byte lane2");
    hostOp(1, 2'd1, 2'b01, 0, 1, 32'h0, "R9 word lane1");
    hostOp(1, 2'd3, 2'b01, 0, 1, 32'h0, "R9 word lane3");
    hostOp(1, 2'd3, 2'b00, 0, 1, 32'h0, "R9 byte lane3");
    // R10: data holds between reads
    repeat (3) @(negedge clk);
    chk(hostRdData == {24'b0, devWord(8'h08, 8'h10)[31:24]}, "R10 data held",
        hostRdData, {24'b0, devWord(8'h08, 8'h10)[31:24]});
    // R8: writes
    hostOp(1, 2'd3, 2'b00, 1, 0, 32'h0000_00AB, "R8 byte write lane3");
    hostOp(1, 2'd0, 2'b10, 1, 0, 32'hDEAD_BEEF, "R8 dword write");
    hostOp(1, 2'd2, 2'b01, 1, 0, 32'h0000_C0DE, "R8 word write lane2");
    hostOp(1, 2'd3, 2'b01, 1, 0, 32'h0000_7766, "R8 word write lane3");
    // R5: enable clear
    hostOp(0, 2'd0, 2'b10, 1, 0, 32'h0000_0810, "R5 disable");
    hostOp(1, 2'd0, 2'b10, 0, 1, 32'h0, "R5 read zero");
    hostOp(1, 2'd0, 2'b10, 1, 0, 32'h1111_1111, "R5 write dropped");
    // R6: misaligned selector, exact readback
    hostOp(0, 2'd0, 2'b10, 1, 0, 32'h8000_0811, "R6 misalign");
    hostOp(0, 2'd0, 2'b10, 0, 1, 32'h0, "R6 R2 readback");
    hostOp(1, 2'd0, 2'b10, 0, 1, 32'h0, "R6 read zero");
    hostOp(1, 2'd1, 2'b00, 1, 0, 32'h0000_0022, "R6 write dropped");
    // R7: absent function and nonzero bus
    hostOp(0, 2'd0, 2'b10, 1, 0, 32'h8000_1800, "R7 absent devfn");
    hostOp(1, 2'd0, 2'b10, 0, 1, 32'h0, "R7 absent read zero");
    hostOp(1, 2'd0, 2'b10, 1, 0, 32'h3333_3333, "R7 absent write dropped");
    hostOp(0, 2'd0, 2'b10, 1, 0, 32'h8001_0800, "R7 bus one");
    hostOp(1, 2'd0, 2'b10, 0, 1, 32'h0, "R7 bus read zero");
    // Present function 0x10, dword read
    hostOp(0, 2'd0, 2'b10, 1, 0, 32'h8000_1004, "R4 devfn 0x10");
    hostOp(1, 2'd0, 2'b10, 0, 1, 32'h0, "R9 devfn 0x10 read");
    // R11: simultaneous write and read
    hostOp(1, 2'd0, 2'b10, 1, 1, 32'h5555_AAAA, "R11 write wins");
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10 R11 scoreboard empty", expQ.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule